// File: doc/BRIEF.md
# Sound-Generator CPU Register Interface

This block is the processor-facing side of a three-channel programmable sound generator. It holds the sixteen 8-bit control registers and the two 8-bit general-purpose I/O ports. Three bus-control strobes select one operation per cycle. The processor first captures a register number from the data bus. It then writes that register, or reads it back on the data bus, in later cycles.

Readback clears the bits that each register does not implement. The two port registers read differently. A port configured as an input returns its pin value. A port configured as an output returns the bitwise AND of its stored latch and its pin value. Each port also has a "driven" flag. When that flag is low, nothing drives the pins and they read as all ones.

The stored port latches go out on dedicated output pins, whatever the direction setting. Tone, noise, envelope and mixing generation sit in other blocks.

Top module: `psg_bus_regs`

## Requirements
- R1: The bus operation is decoded from {busDir, busCtl2, busCtl1}. The codes 3'b001, 3'b100 and 3'b111 capture an address. 3'b110 writes the selected register. 3'b011 reads it. The codes 3'b000, 3'b010 and 3'b101 are inactive and change no stored state.
- R2: An address capture stores the full 8-bit dataIn as the selected register number on the clock edge. That number is kept until the next capture.
- R3: A write stores dataIn into the selected register (0 to 15) on the clock edge. A write while the selected number is above 15 changes no register.
- R4: dataOut is 8'hFF whenever the current operation is not a read. During a read it shows the read value in the same cycle, without waiting for a clock edge.
- R5: Reads of registers 0 to 13 return the stored value ANDed with a mask. The mask is 8'hFF for registers 0, 2, 4, 7, 11 and 12. It is 8'h0F for registers 1, 3, 5 and 13. It is 8'h1F for registers 6, 8, 9 and 10.
- R6: A read with a selected number above 15 returns 8'hFF.
- R7: portAOut always equals register 14 and portBOut always equals register 15, whatever the direction bits hold.
- R8: When register 7 bit 6 is set (port A) or bit 7 is set (port B), that port counts as an output. Reading its register (14 or 15) returns the stored latch ANDed with the effective pin value.
- R9: When the direction bit of a port is clear, reading its register returns the effective pin value alone.
- R10: When a port's driven flag is low, its effective pin value is 8'hFF.
- R11: After reset, all registers and the selected number are zero. Both port outputs are 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busDir | input | 1 | Bus direction strobe |
| busCtl1 | input | 1 | Bus control strobe 1 |
| busCtl2 | input | 1 | Bus control strobe 2 |
| dataIn | input | 8 | Data bus from the processor |
| dataOut | output | 8 | Data bus to the processor, 8'hFF when not reading |
| portAIn | input | 8 | Port A pin input |
| portADriven | input | 1 | High when an external device drives port A |
| portBIn | input | 8 | Port B pin input |
| portBDriven | input | 1 | High when an external device drives port B |
| portAOut | output | 8 | Port A output latch (register 14) |
| portBOut | output | 8 | Port B output latch (register 15) |

## Verification
Two functions can meet in a single cycle. A port readback depends both on the direction bits in register 7 and on the live pin value. So a write to register 7 followed directly by a read of a port must use the new direction. A pin or driven-flag change must show on dataOut within the same read cycle. The bench provokes both cases. It writes the direction register, then reads the port in the next bus cycle. It also changes pins and driven flags just before a read. A scoreboard compares each read cycle's dataOut against a value the bench computes from the latch, the pins and the direction.

// File: rtl/psg_bus_pkg.sv
package psg_bus_pkg;

  // Per-cycle command from the control decoder to the datapath
  typedef struct packed {
    logic latchAddr;
    logic writeReg;
    logic readReg;
  } busStrobes_t;

  // Raw bus operation classes
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LATCH = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } busOp_e;

  // Implemented-bit mask for ordinary register readback
  function automatic logic [7:0] readMask(input int idx);
    case (idx)
      1, 3, 5, 13:  return 8'h0F;
      6, 8, 9, 10:  return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/psg_bus_ctrl.sv
module psg_bus_ctrl
  import psg_bus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busDir,
  input  logic        busCtl1,
  input  logic        busCtl2,
  output busStrobes_t strobes
);

  busOp_e curOp;

  // Decode {dir, ctl2, ctl1} into one operation
  always_comb begin
    case ({busDir, busCtl2, busCtl1})
      3'b001, 3'b100, 3'b111: curOp = OP_LATCH;
      3'b110:                 curOp = OP_WRITE;
      3'b011:                 curOp = OP_READ;
      default:                curOp = OP_IDLE;
    endcase
  end

  always_comb begin
    strobes           = '0;
    strobes.latchAddr = (curOp == OP_LATCH);
    strobes.writeReg  = (curOp == OP_WRITE);
    strobes.readReg   = (curOp == OP_READ);
  end

  // R1: at most one operation per cycle
  a_r1_one_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R1: inactive codes raise no strobe
  a_r1_idle_codes: assert property (@(posedge clk) disable iff (!rstN)
    ({busDir, busCtl2, busCtl1} == 3'b000 || {busDir, busCtl2, busCtl1} == 3'b010 ||
     {busDir, busCtl2, busCtl1} == 3'b101) |-> (strobes == '0));

endmodule

// File: rtl/psg_bus_datapath.sv
module psg_bus_datapath
  import psg_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 16,
  parameter int MIX_REG     = 7,
  parameter int PORT_BASE   = 14,
  parameter int DIR_BIT_LOW = 6,
  parameter int NUM_PORTS   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  busStrobes_t             strobes,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] portIn,
  input  logic [NUM_PORTS-1:0]    portDriven,
  output logic [DATA_W-1:0]       dataOut,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] portOut
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] selAddr;
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic              addrInRange;
  logic [IDX_W-1:0]  selIdx;

  assign addrInRange = (selAddr < DATA_W'(NUM_REGS));
  assign selIdx      = selAddr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selAddr <= '0;
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      if (strobes.latchAddr) selAddr <= dataIn;
      if (strobes.writeReg && addrInRange) regFile[selIdx] <= dataIn;
    end
  end

  // Port pins, direction and readback
  logic [NUM_PORTS-1:0][DATA_W-1:0] pinValue;
  logic [NUM_PORTS-1:0][DATA_W-1:0] portRead;
  logic [NUM_PORTS-1:0]             isOutput;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    assign portOut[g]  = regFile[PORT_BASE + g];
    assign pinValue[g] = portDriven[g] ? portIn[g] : '1;
    assign isOutput[g] = regFile[MIX_REG][DIR_BIT_LOW + g];
    assign portRead[g] = isOutput[g] ? (pinValue[g] & regFile[PORT_BASE + g]) : pinValue[g];
  end

  // Masked readback of the selected register
  logic [DATA_W-1:0] regRead;
  always_comb begin
    regRead = regFile[selIdx] & DATA_W'(readMask(int'(selIdx)));
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (selIdx == IDX_W'(PORT_BASE + p)) regRead = portRead[p];
    end
  end

  assign dataOut = (strobes.readReg && addrInRange) ? regRead : '1;

  // R2: capture takes the bus value
  a_r2_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchAddr |=> (selAddr == $past(dataIn)));

  // R3: write lands in the selected register
  a_r3_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeReg && addrInRange) |=> (regFile[$past(selIdx)] == $past(dataIn)));

  // R6: out-of-range read gives all ones
  a_r6_high_addr: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readReg && !addrInRange) |-> (dataOut == '1));

  // R7: port output pins follow a write to the port register
  a_r7_port_pins: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeReg && addrInRange && selIdx == IDX_W'(PORT_BASE)) |=> (portOut[0] == $past(dataIn)));

  // R10: undriven input-mode port reads all ones
  a_r10_undriven: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readReg && addrInRange && selIdx == IDX_W'(PORT_BASE) && !portDriven[0] && !isOutput[0])
      |-> (dataOut == '1));

endmodule

// File: rtl/psg_bus_regs.sv
module psg_bus_regs
  import psg_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 16,
  parameter int MIX_REG     = 7,
  parameter int PORT_BASE   = 14,
  parameter int DIR_BIT_LOW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busDir,
  input  logic              busCtl1,
  input  logic              busCtl2,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  input  logic [DATA_W-1:0] portAIn,
  input  logic              portADriven,
  input  logic [DATA_W-1:0] portBIn,
  input  logic              portBDriven,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portBOut
);

  busStrobes_t strobes;
  logic [1:0][DATA_W-1:0] portInBus;
  logic [1:0][DATA_W-1:0] portOutBus;

  assign portInBus = {portBIn, portAIn};
  assign portAOut  = portOutBus[0];
  assign portBOut  = portOutBus[1];

  psg_bus_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busDir  (busDir),
    .busCtl1 (busCtl1),
    .busCtl2 (busCtl2),
    .strobes (strobes)
  );

  psg_bus_datapath #(
    .DATA_W      (DATA_W),
    .NUM_REGS    (NUM_REGS),
    .MIX_REG     (MIX_REG),
    .PORT_BASE   (PORT_BASE),
    .DIR_BIT_LOW (DIR_BIT_LOW),
    .NUM_PORTS   (2)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .dataIn     (dataIn),
    .portIn     (portInBus),
    .portDriven ({portBDriven, portADriven}),
    .dataOut    (dataOut),
    .portOut    (portOutBus)
  );

  // R4: bus idles high outside a read
  a_r4_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    ({busDir, busCtl2, busCtl1} != 3'b011) |-> (dataOut == '1));

endmodule

// File: tb/tb_psg_bus_regs.sv
module tb_psg_bus_regs;

  localparam logic [2:0] C_IDLE  = 3'b000;
  localparam logic [2:0] C_LATCH = 3'b111;
  localparam logic [2:0] C_WRITE = 3'b110;
  localparam logic [2:0] C_READ  = 3'b011;

  logic clk = 1'b0;
  logic rstN;
  logic busDir, busCtl1, busCtl2;
  logic [7:0] dataIn, dataOut;
  logic [7:0] portAIn, portBIn, portAOut, portBOut;
  logic portADriven, portBDriven;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  psg_bus_regs dut (
    .clk(clk), .rstN(rstN), .busDir(busDir), .busCtl1(busCtl1), .busCtl2(busCtl2),
    .dataIn(dataIn), .dataOut(dataOut),
    .portAIn(portAIn), .portADriven(portADriven),
    .portBIn(portBIn), .portBDriven(portBDriven),
    .portAOut(portAOut), .portBOut(portBOut)
  );

  task automatic checkEq(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle, then back to idle
  task automatic busCycle(input logic [2:0] code, input logic [7:0] d);
    {busDir, busCtl2, busCtl1} = code;
    dataIn = d;
    @(posedge clk);
    #1;
    {busDir, busCtl2, busCtl1} = C_IDLE;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] v);
    busCycle(C_LATCH, a);
    busCycle(C_WRITE, v);
  endtask

  task automatic readCur(input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busCycle(C_READ, 8'h00);
  endtask

  task automatic readReg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    busCycle(C_LATCH, a);
    readCur(exp, tag);
  endtask

  // Monitor: pop one expectation per read cycle
  always @(negedge clk) begin
    if (rstN === 1'b1 && {busDir, busCtl2, busCtl1} == C_READ) begin
      if (expQ.size() == 0) begin
        checkEq("R4 unexpected read", dataOut, 8'hxx);
      end else begin
        checkEq(tagQ.pop_front(), dataOut, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    {busDir, busCtl2, busCtl1} = C_IDLE;
    dataIn = 8'h00;
    portAIn = 8'h00; portBIn = 8'h00;
    portADriven = 1'b0; portBDriven = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checkEq("R11 portAOut reset", portAOut, 8'h00);
    checkEq("R11 portBOut reset", portBOut, 8'h00);
    checkEq("R4 idle bus", dataOut, 8'hFF);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R11: selected number is 0 after reset
    readCur(8'h00, "R11 reg0 after reset");

    // R3 / R5: writes and masked reads
    writeReg(8'd0, 8'hA5);  readReg(8'd0, 8'hA5, "R3 reg0");
    writeReg(8'd1, 8'hFF);  readReg(8'd1, 8'h0F, "R5 reg1 mask");
    writeReg(8'd6, 8'hFF);  readReg(8'd6, 8'h1F, "R5 reg6 mask");
    writeReg(8'd8, 8'hEE);  readReg(8'd8, 8'h0E, "R5 reg8 mask");
    writeReg(8'd13, 8'hFF); readReg(8'd13, 8'h0F, "R5 reg13 mask");
    writeReg(8'd11, 8'hC3); readReg(8'd11, 8'hC3, "R5 reg11 mask");

    // R6 / R3: out-of-range address
    writeReg(8'd20, 8'h77);
    readCur(8'hFF, "R6 read addr 20");
    readReg(8'd4, 8'h00, "R3 write to 20 ignored");

    // R1 / R2: alternate capture codes
    busCycle(3'b001, 8'd0);
    readCur(8'hA5, "R2 capture code 001");
    busCycle(3'b100, 8'd1);
    readCur(8'h0F, "R2 capture code 100");

    // R1: inactive codes change nothing
    busCycle(C_LATCH, 8'd0);
    busCycle(3'b010, 8'h11);
    busCycle(3'b101, 8'h22);
    busCycle(3'b000, 8'h33);
    readCur(8'hA5, "R1 inactive codes");
    {busDir, busCtl2, busCtl1} = 3'b010;
    #1;
    checkEq("R4 inactive bus", dataOut, 8'hFF);
    {busDir, busCtl2, busCtl1} = C_IDLE;
    @(posedge clk); #1;

    // Ports: both inputs
    writeReg(8'd7, 8'h00);
    writeReg(8'd14, 8'h3C);
    checkEq("R7 portAOut", portAOut, 8'h3C);
    portAIn = 8'hF0; portADriven = 1'b1;
    readReg(8'd14, 8'hF0, "R9 port A input");
    portADriven = 1'b0;
    readReg(8'd14, 8'hFF, "R10 port A undriven input");

    // Port A output: direction change then immediate read
    writeReg(8'd7, 8'h40);
    portADriven = 1'b1;
    readReg(8'd14, 8'h30, "R8 port A output AND");
    checkEq("R7 portAOut after dir", portAOut, 8'h3C);
    portADriven = 1'b0;
    readReg(8'd14, 8'h3C, "R10 port A undriven output");
    readReg(8'd7, 8'h40, "R5 reg7 full");

    // Port B
    writeReg(8'd15, 8'hC3);
    checkEq("R7 portBOut", portBOut, 8'hC3);
    writeReg(8'd7, 8'h80);
    portBIn = 8'h0F; portBDriven = 1'b1;
    readReg(8'd15, 8'h03, "R8 port B output AND");
    readReg(8'd14, 8'hFF, "R9 port A back to input undriven");
    writeReg(8'd7, 8'h00);
    readReg(8'd15, 8'h0F, "R9 port B input");
    // pin change right before the read cycle
    busCycle(C_LATCH, 8'd15);
    portBIn = 8'h5A;
    readCur(8'h5A, "R9 port B pin change");
    checkEq("R7 portBOut input mode", portBOut, 8'hC3);

    @(posedge clk); #1;
    checkEq("R4 queue drained", 8'(expQ.size()), 8'h00);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule